// File: doc/BRIEF.md
# Serial SAR Converter Conversion and Readout Sequencer

This block sits on the host side of a fast successive-approximation converter that has a serial differential data link. Whenever a start request is present and the minimum conversion spacing has passed, it raises the conversion-start line for a fixed number of system clock cycles. It then waits out the conversion latency and sends a burst of read clocks. It shifts the returned bits in, most significant first, and presents the 16-bit sample on a parallel bus together with a one-cycle valid strobe.

There are two read modes. In echoed mode the converter returns a copy of the read clock, and each bit is taken on a rising edge of that returned clock. In self-clocked mode the frame is two bits longer: each bit is sampled on the falling edge of the block's own read clock, and the two leading header bits are dropped. The mode is sampled when a conversion starts and then applies to that conversion's whole frame.

The pulse width, spacing, latency, idle limit, read-clock half period and read deadline are all parameters counted in system clock cycles. Any combination that would let a read burst overrun its window is rejected at elaboration. A result that follows a start-line idle period longer than the idle limit carries a bad flag, and so does the first result after reset.

Top module: `sar_readout_seq`

## Requirements
- R1: While reset is active, and after it until the first request, `cnv_o`, `rclk_o`, `result_valid_o` and `result_bad_o` are 0 and `result_o` is 0.
- R2: Each conversion-start pulse on `cnv_o` is high for exactly CNV_HIGH cycles.
- R3: Two rising edges of `cnv_o` are never less than CONV_CYC cycles apart. While `start_req_i` stays high they are exactly CONV_CYC cycles apart.
- R4: The first rising edge of `rclk_o` for a conversion comes exactly LAT cycles after that conversion's `cnv_o` rising edge, and no read clock is issued in between.
- R5: Every read-clock pulse is high for RCLK_HALF cycles and low for RCLK_HALF cycles. A frame has 16 pulses when `mode_i` = 0 (echoed) and 18 pulses when `mode_i` = 1 (self-clocked).
- R6: The last read-clock falling edge of a frame comes LAT + (2·N−1)·RCLK_HALF cycles after its `cnv_o` rise, where N is the frame length. This is never later than CONV_CYC + DEADLINE cycles after that rise. Parameters that break this bound are rejected at elaboration.
- R7: In echoed mode, one bit of `sdata_i` is taken for each rising edge of `echo_clk_i`, first bit in the MSB position, and the 16 bits form `result_o`.
- R8: In self-clocked mode, `sdata_i` is sampled at each read-clock falling edge. The first two of the 18 bits are a header and are dropped, and the remaining 16 form `result_o`, MSB first.
- R9: The mode used for a frame is the value of `mode_i` on the clock edge that raises `cnv_o`. Changing `mode_i` later has no effect on that frame.
- R10: `result_valid_o` is a one-cycle pulse after the last bit of a frame is captured, with one pulse per conversion. `result_o` changes only in the cycle `result_valid_o` is high.
- R11: `result_bad_o`, valid alongside the strobe, is 1 for the first conversion after reset. It is also 1 when the gap from the previous `cnv_o` rise exceeds MAX_IDLE cycles. It is 0 for gaps of MAX_IDLE cycles or fewer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req_i | input | 1 | Level request to keep converting |
| mode_i | input | 1 | 0 = echoed-clock read, 1 = self-clocked read |
| cnv_o | output | 1 | Conversion-start pulse to the converter |
| rclk_o | output | 1 | Read clock burst to the converter |
| echo_clk_i | input | 1 | Clock returned by the converter in echoed mode |
| sdata_i | input | 1 | Serial data from the converter |
| result_o | output | 16 | Last complete sample |
| result_valid_o | output | 1 | One-cycle strobe for a new sample |
| result_bad_o | output | 1 | Sample follows an over-long idle period or reset |

## Verification
The bench targets idle gaps of exactly MAX_IDLE and MAX_IDLE+1 cycles. A comparator that is off by one flags the good sample or passes the bad one. It changes the mode between a start and its read burst and again in the middle of a burst. A design that reads the mode at launch or on every bit would then send the wrong number of clocks, which moves the final falling edge. The self-clocked frames carry a fixed 01 header ahead of samples such as 0xFFFF and 0x8001, so a wrong slice or a reversed bit order changes the value. Burst start and end times are measured against the start pulse to the exact cycle, which catches any extra or missing pulse.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    MODE_ECHO = 1'b0,
    MODE_SELF = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/sar_seq_rst_sync.sv
module sar_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/sar_seq_conv_timer.sv
module sar_seq_conv_timer
  import sar_seq_pkg::*;
#(
  parameter int CNV_HIGH = 2,
  parameter int CONV_CYC = 40,
  parameter int MAX_IDLE = 200,
  parameter int LAT      = 10
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  rd_mode_e mode_i,
  output logic     cnv_o,
  output logic     launch_o,
  output rd_mode_e mode_o,
  output logic     bad_o
);

  localparam int SAT = MAX_IDLE + 1;
  localparam int EW  = $clog2(SAT + 1);
  localparam int HW  = (CNV_HIGH > 1) ? $clog2(CNV_HIGH) : 1;
  localparam int LW  = (LAT > 1) ? $clog2(LAT) : 1;

  logic [EW-1:0] elapsed_q, elapsed_d;
  logic          sat, fire;

  logic          cnv_q, cnv_d;
  logic [HW-1:0] hi_q, hi_d;
  logic          pulse_en;

  logic          lat_run_q, lat_run_d;
  logic [LW-1:0] lat_q, lat_d;
  logic          lat_en;

  rd_mode_e      cmode_q;
  logic          cbad_q;

  // spacing / idle counter, saturating one past the idle limit
  assign sat  = (elapsed_q == EW'(SAT));
  assign fire = req_i && (elapsed_q >= EW'(CONV_CYC));

  always_comb begin
    if (fire)     elapsed_d = EW'(1);
    else if (sat) elapsed_d = elapsed_q;
    else          elapsed_d = elapsed_q + EW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elapsed_q <= EW'(SAT);
    else         elapsed_q <= elapsed_d;
  end

  // start pulse width
  assign pulse_en = fire | cnv_q;

  always_comb begin
    cnv_d = cnv_q;
    hi_d  = hi_q;
    if (fire) begin
      cnv_d = 1'b1;
      hi_d  = HW'(CNV_HIGH - 1);
    end else if (cnv_q) begin
      if (hi_q == '0) cnv_d = 1'b0;
      else            hi_d  = hi_q - HW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_q <= 1'b0;
      hi_q  <= '0;
    end else if (pulse_en) begin
      cnv_q <= cnv_d;
      hi_q  <= hi_d;
    end
  end

  // conversion latency before the read burst may begin
  assign lat_en = fire | lat_run_q;

  always_comb begin
    lat_run_d = lat_run_q;
    lat_d     = lat_q;
    if (fire) begin
      lat_run_d = 1'b1;
      lat_d     = LW'(LAT - 1);
    end else if (lat_run_q) begin
      if (lat_q == '0) lat_run_d = 1'b0;
      else             lat_d     = lat_q - LW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_run_q <= 1'b0;
      lat_q     <= '0;
    end else if (lat_en) begin
      lat_run_q <= lat_run_d;
      lat_q     <= lat_d;
    end
  end

  // per-conversion attributes captured at the start edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmode_q <= MODE_ECHO;
      cbad_q  <= 1'b0;
    end else if (fire) begin
      cmode_q <= mode_i;
      cbad_q  <= sat;
    end
  end

  assign cnv_o    = cnv_q;
  assign launch_o = lat_run_q && (lat_q == '0);
  assign mode_o   = cmode_q;
  assign bad_o    = cbad_q;

  AST_LAUNCH_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> !cnv_q); // R4

  AST_NO_EARLY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_q) |-> !lat_run_q || (lat_q == LW'(LAT - 1))); // R3

endmodule

// File: rtl/sar_seq_read_engine.sv
module sar_seq_read_engine
  import sar_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HDR_W     = 2,
  parameter int RCLK_HALF = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  rd_mode_e          mode_i,
  input  logic              bad_i,
  input  logic              echo_clk_i,
  input  logic              sdata_i,
  output logic              rclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              bad_o
);

  localparam int NB_MAX = DATA_W + HDR_W;
  localparam int BW     = $clog2(NB_MAX + 1);
  localparam int HCW    = (RCLK_HALF > 1) ? $clog2(RCLK_HALF) : 1;

  // read clock generator
  logic           busy_q, busy_d;
  logic           rclk_q, rclk_d;
  logic [HCW-1:0] hc_q, hc_d;
  logic [BW-1:0]  bl_q, bl_d;
  logic [BW-1:0]  nb;
  logic           gen_en;
  logic           fall_now;

  rd_mode_e       fmode_q;
  logic           fbad_q;

  // capture path
  logic              echo_q, echo_qq, sd_q;
  logic              echo_rise;
  logic [BW-1:0]     cap_left_q, cap_left_d;
  logic [DATA_W-2:0] sr_q;
  logic              cap_en, cap_bit, last_cap, cap_load_en;
  logic [DATA_W-1:0] res_q;
  logic              val_q, rbad_q;

  assign nb       = (mode_i == MODE_SELF) ? BW'(NB_MAX) : BW'(DATA_W);
  assign gen_en   = launch_i | busy_q;
  assign fall_now = busy_q && rclk_q && (hc_q == '0);

  always_comb begin
    busy_d = busy_q;
    rclk_d = rclk_q;
    hc_d   = hc_q;
    bl_d   = bl_q;
    if (launch_i) begin
      busy_d = 1'b1;
      rclk_d = 1'b1;
      hc_d   = HCW'(RCLK_HALF - 1);
      bl_d   = nb - BW'(1);
    end else if (busy_q) begin
      if (hc_q != '0) begin
        hc_d = hc_q - HCW'(1);
      end else if (rclk_q) begin
        rclk_d = 1'b0;
        hc_d   = HCW'(RCLK_HALF - 1);
      end else if (bl_q == '0) begin
        busy_d = 1'b0;
      end else begin
        rclk_d = 1'b1;
        bl_d   = bl_q - BW'(1);
        hc_d   = HCW'(RCLK_HALF - 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rclk_q <= 1'b0;
      hc_q   <= '0;
      bl_q   <= '0;
    end else if (gen_en) begin
      busy_q <= busy_d;
      rclk_q <= rclk_d;
      hc_q   <= hc_d;
      bl_q   <= bl_d;
    end
  end

  // frame attributes fixed for the whole burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmode_q <= MODE_ECHO;
      fbad_q  <= 1'b0;
    end else if (launch_i) begin
      fmode_q <= mode_i;
      fbad_q  <= bad_i;
    end
  end

  // input registers for the echoed path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      echo_q  <= 1'b0;
      echo_qq <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      echo_q  <= echo_clk_i;
      echo_qq <= echo_q;
      sd_q    <= sdata_i;
    end
  end

  assign echo_rise = echo_q && !echo_qq;
  assign cap_en    = (cap_left_q != '0) &&
                     ((fmode_q == MODE_SELF) ? fall_now : echo_rise);
  assign cap_bit   = (fmode_q == MODE_SELF) ? sdata_i : sd_q;
  assign last_cap  = cap_en && (cap_left_q == BW'(1));

  assign cap_load_en = launch_i | cap_en;

  always_comb begin
    if (launch_i) cap_left_d = nb;
    else          cap_left_d = cap_left_q - BW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cap_left_q <= '0;
    else if (cap_load_en) cap_left_q <= cap_left_d;
  end

  // shift register keeps only the bits that can still reach the result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (cap_en) sr_q <= {sr_q[DATA_W-3:0], cap_bit};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      rbad_q <= 1'b0;
    end else if (last_cap) begin
      res_q  <= {sr_q, cap_bit};
      rbad_q <= fbad_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= 1'b0;
    else         val_q <= last_cap;
  end

  assign rclk_o   = rclk_q;
  assign result_o = res_q;
  assign valid_o  = val_q;
  assign bad_o    = rbad_q;

  AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q); // R6

  AST_RCLK_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rclk_q |-> busy_q); // R5

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> valid_o); // R10

  AST_SELF_CAP_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en && fmode_q == MODE_SELF) |-> busy_q); // R8

endmodule

// File: rtl/sar_readout_seq.sv
module sar_readout_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HDR_W      = 2,
  parameter int CNV_HIGH   = 2,
  parameter int CONV_CYC   = 40,
  parameter int MAX_IDLE   = 200,
  parameter int LAT        = 10,
  parameter int DEADLINE   = 6,
  parameter int RCLK_HALF  = 1,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic              mode_i,
  output logic              cnv_o,
  output logic              rclk_o,
  input  logic              echo_clk_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic              result_bad_o
);

  localparam int NB_MAX   = DATA_W + HDR_W;
  localparam int BURST    = 2 * NB_MAX * RCLK_HALF;
  localparam int LAST_END = LAT + (2 * NB_MAX - 1) * RCLK_HALF;

  // elaboration-time window checks (R6)
  if (CNV_HIGH < 1 || RCLK_HALF < 1 || DATA_W < 3 || RST_STAGES < 2) begin : g_bad_basic
    $error("sar_readout_seq: width, half period or stage count too small");
  end
  if (LAT <= CNV_HIGH || LAT >= CONV_CYC) begin : g_bad_latency
    $error("sar_readout_seq: latency must lie between pulse width and cycle");
  end
  if (CONV_CYC > MAX_IDLE) begin : g_bad_idle
    $error("sar_readout_seq: idle limit shorter than conversion cycle");
  end
  if (BURST >= CONV_CYC) begin : g_bad_burst
    $error("sar_readout_seq: read burst longer than conversion cycle");
  end
  if (LAST_END > CONV_CYC + DEADLINE) begin : g_bad_deadline
    $error("sar_readout_seq: read burst overruns the deadline after next start");
  end

  logic     rst_sync_n;
  logic     launch;
  rd_mode_e conv_mode;
  logic     conv_bad;

  sar_seq_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  sar_seq_conv_timer #(
    .CNV_HIGH(CNV_HIGH),
    .CONV_CYC(CONV_CYC),
    .MAX_IDLE(MAX_IDLE),
    .LAT     (LAT)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .req_i   (start_req_i),
    .mode_i  (rd_mode_e'(mode_i)),
    .cnv_o   (cnv_o),
    .launch_o(launch),
    .mode_o  (conv_mode),
    .bad_o   (conv_bad)
  );

  sar_seq_read_engine #(
    .DATA_W   (DATA_W),
    .HDR_W    (HDR_W),
    .RCLK_HALF(RCLK_HALF)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .launch_i  (launch),
    .mode_i    (conv_mode),
    .bad_i     (conv_bad),
    .echo_clk_i(echo_clk_i),
    .sdata_i   (sdata_i),
    .rclk_o    (rclk_o),
    .result_o  (result_o),
    .valid_o   (result_valid_o),
    .bad_o     (result_bad_o)
  );

  AST_RCLK_AFTER_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(cnv_o) |-> !launch); // R4

endmodule

// File: tb/sar_readout_seq_bench.sv
module sar_readout_seq_bench;

  localparam int DATA_W    = 16;
  localparam int HDR_W     = 2;
  localparam int CNV_HIGH  = 2;
  localparam int CONV_CYC  = 40;
  localparam int MAX_IDLE  = 200;
  localparam int LAT       = 10;
  localparam int DEADLINE  = 6;
  localparam int RCLK_HALF = 1;

  logic clk = 1'b0;
  logic rst_ni;
  logic start_req_i = 1'b0;
  logic mode_i = 1'b0;
  logic echo_clk_i = 1'b0;
  logic sdata_i = 1'b0;
  logic cnv_o, rclk_o, result_valid_o, result_bad_o;
  logic [DATA_W-1:0] result_o;

  always #4 clk = ~clk;

  sar_readout_seq #(
    .DATA_W(DATA_W), .HDR_W(HDR_W), .CNV_HIGH(CNV_HIGH), .CONV_CYC(CONV_CYC),
    .MAX_IDLE(MAX_IDLE), .LAT(LAT), .DEADLINE(DEADLINE), .RCLK_HALF(RCLK_HALF),
    .RST_STAGES(2)
  ) u_sar_readout_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_req_i(start_req_i), .mode_i(mode_i),
    .cnv_o(cnv_o), .rclk_o(rclk_o), .echo_clk_i(echo_clk_i), .sdata_i(sdata_i),
    .result_o(result_o), .result_valid_o(result_valid_o), .result_bad_o(result_bad_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sample_of(int n);
    case (n % 5)
      0:       return 16'hFFFF;
      1:       return 16'h0000;
      2:       return 16'h8001;
      default: return 16'((n * 15643) ^ 42405);
    endcase
  endfunction

  // reference model state
  int cyc = 0;
  int nconv = 0;
  int nvalid = 0;
  int last_rise = -1;
  bit req_dropped = 0;
  bit p_cnv = 0, p_rclk = 0, p_val = 0;
  logic [15:0] p_res = '0;
  bit res_changed = 0;
  int cnv_hi = 0;
  int rhigh = 0;

  int          q_t[$];
  bit          q_mode[$];
  logic [15:0] q_s[$];
  bit          q_bad[$];
  logic [15:0] e_s[$];
  bit          e_bad[$];
  bit          e_mode[$];

  bit          in_frame = 0;
  int          f_t, f_nb, f_rises;
  bit          f_mode;
  logic [17:0] f_word;

  always @(posedge clk) begin
    #1;
    if (!rst_ni) begin
      last_rise = -1; in_frame = 0; p_cnv = 0; p_rclk = 0; p_val = 0; p_res = '0;
      q_t.delete(); q_mode.delete(); q_s.delete(); q_bad.delete();
      e_s.delete(); e_bad.delete(); e_mode.delete();
      echo_clk_i = 0; sdata_i = 0;
    end else begin
      cyc++;
      if (!start_req_i) req_dropped = 1;

      // start pulse: spacing, width, per-conversion expectations
      if (cnv_o && !p_cnv) begin
        int gap;
        gap = cyc - last_rise;
        if (last_rise >= 0) begin
          chk(gap >= CONV_CYC, "R3", "start spacing", gap, CONV_CYC);
          if (!req_dropped) chk(gap == CONV_CYC, "R3", "spacing under steady request", gap, CONV_CYC);
        end
        q_t.push_back(cyc);
        q_mode.push_back(mode_i);
        q_s.push_back(sample_of(nconv));
        q_bad.push_back((last_rise < 0) || (gap > MAX_IDLE));
        nconv++;
        last_rise = cyc;
        req_dropped = 0;
        cnv_hi = 1;
      end else if (cnv_o) begin
        cnv_hi++;
      end
      if (!cnv_o && p_cnv) chk(cnv_hi == CNV_HIGH, "R2", "start pulse width", cnv_hi, CNV_HIGH);

      // read clock and converter model
      if (rclk_o && !p_rclk) begin
        if (!in_frame) begin
          if (q_t.size() == 0) begin
            chk(0, "R4", "read clock without pending conversion", 1, 0);
          end else begin
            logic [15:0] s;
            f_t = q_t.pop_front();
            f_mode = q_mode.pop_front();
            s = q_s.pop_front();
            f_nb = f_mode ? 18 : 16;
            f_word = f_mode ? {2'b01, s} : {2'b00, s};
            f_rises = 0;
            in_frame = 1;
            e_s.push_back(s);
            e_bad.push_back(q_bad.pop_front());
            e_mode.push_back(f_mode);
            chk(cyc - f_t == LAT, "R4", "first read clock delay", cyc - f_t, LAT);
          end
        end
        if (in_frame && f_rises < f_nb) sdata_i = f_word[f_nb - 1 - f_rises];
        if (in_frame && !f_mode) echo_clk_i = 1;
        f_rises++;
        rhigh = 1;
      end else if (rclk_o) begin
        rhigh++;
      end
      if (!rclk_o && p_rclk) begin
        echo_clk_i = 0;
        chk(rhigh == RCLK_HALF, "R5", "read clock high time", rhigh, RCLK_HALF);
        if (in_frame && f_rises == f_nb) begin
          int expd;
          expd = LAT + (2 * f_nb - 1) * RCLK_HALF;
          chk(cyc - f_t == expd, "R5", "frame pulse count via end time", cyc - f_t, expd);
          chk(cyc - f_t <= CONV_CYC + DEADLINE, "R6", "last read clock deadline", cyc - f_t, CONV_CYC + DEADLINE);
          if (mode_i != f_mode) chk(cyc - f_t == expd, "R9", "frame kept start-time mode", cyc - f_t, expd);
          in_frame = 0;
        end
      end

      // result strobe
      if (result_valid_o) begin
        chk(!p_val, "R10", "strobe longer than one cycle", p_val, 0);
        chk(!res_changed, "R10", "result changed outside strobe", res_changed, 0);
        res_changed = 0;
        nvalid++;
        if (e_s.size() == 0) begin
          chk(0, "R10", "strobe without frame", 1, 0);
        end else begin
          logic [15:0] es;
          bit eb, em;
          es = e_s.pop_front(); eb = e_bad.pop_front(); em = e_mode.pop_front();
          if (em) chk(result_o == es, "R8", "self-clocked result", result_o, es);
          else    chk(result_o == es, "R7", "echoed result", result_o, es);
          chk(result_bad_o == eb, "R11", "bad flag", result_bad_o, eb);
        end
      end else if (result_o != p_res) begin
        res_changed = 1;
      end

      p_cnv = cnv_o; p_rclk = rclk_o; p_val = result_valid_o; p_res = result_o;
    end
  end

  task automatic wait_conv(int n);
    while (nconv < n) @(negedge clk);
  endtask

  task automatic set_mode_at(int offs, bit m);
    int n0;
    n0 = nconv;
    while (nconv == n0) @(negedge clk);
    while (cyc < last_rise + offs) @(negedge clk);
    mode_i = m;
  endtask

  // hold the start request off so the next start comes g cycles after the current one
  task automatic gap_of(int g);
    int n0, base;
    n0 = nconv;
    while (nconv == n0) @(negedge clk);
    start_req_i = 0;
    base = last_rise;
    while (cyc < base + g - 1) @(negedge clk);
    start_req_i = 1;
    while (nconv == n0 + 1) @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnv_o == 0 && rclk_o == 0, "R1", "lines during reset", {cnv_o, rclk_o}, 0);
    chk(result_valid_o == 0 && result_bad_o == 0, "R1", "strobe and flag during reset",
        {result_valid_o, result_bad_o}, 0);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    chk(cnv_o == 0 && rclk_o == 0, "R1", "lines idle after reset", {cnv_o, rclk_o}, 0);
    chk(result_o == 0, "R1", "result after reset", result_o, 0);
    chk(result_valid_o == 0, "R1", "no strobe after reset", result_valid_o, 0);

    // echoed frames, first one flagged
    mode_i = 0;
    start_req_i = 1;
    wait_conv(3);
    // mode change between start and burst, then during the burst
    set_mode_at(4, 1'b1);
    wait_conv(7);
    set_mode_at(LAT + 8, 1'b0);
    wait_conv(10);
    set_mode_at(1, 1'b1);
    // idle-gap boundaries
    gap_of(MAX_IDLE);
    gap_of(MAX_IDLE + 1);
    mode_i = 0;
    gap_of(100);
    gap_of(500);
    mode_i = 1;
    gap_of(CONV_CYC + 3);
    wait_conv(nconv + 2);
    start_req_i = 0;
    repeat (120) @(negedge clk);
    chk(nvalid == nconv, "R10", "one strobe per conversion", nvalid, nconv);
    chk(e_s.size() == 0 && q_t.size() == 0, "R10", "no frame left pending", e_s.size() + q_t.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule